// File: doc/BRIEF.md
# Chip-Select Peripheral Bus Controller

This block is the master side of a plain parallel peripheral bus. It takes single-beat read and write requests from an internal port and runs them as strobed bus cycles towards external slave devices. The address lines (26 bits) and the data lines (16 bits) are separate. Data leaves the block on a driven output with an enable, and it comes back in on a separate input, so the pad ring can form the bidirectional data pins. Control uses an address strobe, a data strobe, a read/write line and an active-low transfer-acknowledge input.

Five device profiles each own one active-low chip select. A profile holds an enable, a base address, a window size of up to 64 MB, a completion mode and a 4-bit wait count. A request whose address falls inside an enabled window selects that profile. The profile's mode then decides how the cycle ends: after a fixed number of strobe cycles, or when the slave pulls the acknowledge low. Acknowledge cycles are bounded by a global timeout register. A request that hits no window is answered at once with an error.

The cycle machine has three states: `ST_IDLE`, `ST_STROBE` and `ST_RECOVER`. The transitions are:
- `ST_IDLE` to `ST_STROBE` on an accepted request that hits a window (the accept-hit transition).
- `ST_IDLE` to `ST_RECOVER` on an accepted request that misses (the accept-miss transition).
- `ST_STROBE` to `ST_RECOVER` on completion, which is a wait count reached, an acknowledge seen, or a timeout (the finish transition).
- `ST_RECOVER` to `ST_IDLE` unconditionally (the release transition).

Top module: `csbus_ctrl`

## Requirements
- R1: After reset, `req_ready` is 1, `bus_as_n`, `bus_ds_n` and every `bus_cs_n` bit are 1, `resp_done` is 0, every profile is disabled and the timeout register holds 255.
- R2: During a bus cycle `bus_as_n` and `bus_ds_n` are both 0 and `bus_addr` holds the request address unchanged. `bus_rw` is 1 for a read and 0 for a write. `bus_doe` is 1 with `bus_dout` equal to the write data only during a write strobe.
- R3: Profile p matches when it is enabled and `base <= addr < base + size`, where size is 27 bits so that 2^26 covers the whole space. Only `bus_cs_n[p]` goes low. When windows overlap, the lowest-numbered matching profile wins.
- R4: A request that matches no enabled profile produces no strobe and no chip select. `resp_done` and `resp_err` are 1 in the cycle after acceptance, and `resp_rdata` is 0.
- R5: A profile in wait mode (`cfg_ack` = 0) with wait field N holds the strobe for exactly N+1 cycles, then completes without error.
- R6: A profile in acknowledge mode (`cfg_ack` = 1) completes without error at the first clock edge where `bus_dtack_n` is sampled 0 during the strobe. An acknowledge in the d-th strobe cycle (counting from 0) gives a strobe of d+1 cycles.
- R7: In acknowledge mode with timeout value T (0 behaves as 1), if no acknowledge is seen within T strobe cycles, the strobe ends after T cycles with `resp_err` = 1 and `resp_rdata` = 0.
- R8: The strobe starts in the cycle after acceptance. Only one access is in flight: `req_ready` is 0 from acceptance up to and including the single recovery cycle. In the recovery cycle every strobe and chip select is 1 and `resp_done` pulses for exactly one cycle.
- R9: For a successful read, `resp_rdata` during `resp_done` equals the `bus_din` value sampled on the completing edge. For writes and errors it is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Write one profile |
| cfg_idx | input | 3 | Profile number to write |
| cfg_en | input | 1 | Profile enable |
| cfg_ack | input | 1 | 1 = acknowledge mode, 0 = wait mode |
| cfg_wait | input | 4 | Wait count N (strobe of N+1 cycles) |
| cfg_base | input | 26 | Window base address |
| cfg_size | input | 27 | Window size in address units |
| tmo_we | input | 1 | Write the timeout register |
| tmo_val | input | 8 | Acknowledge timeout in cycles |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 26 | Request address |
| req_wdata | input | 16 | Write data |
| req_ready | output | 1 | Request accepted when high with valid |
| resp_done | output | 1 | One-cycle completion pulse |
| resp_err | output | 1 | Completion was a miss or timeout |
| resp_rdata | output | 16 | Read data |
| bus_addr | output | 26 | External address |
| bus_dout | output | 16 | External write data |
| bus_din | input | 16 | External read data |
| bus_doe | output | 1 | Data output enable |
| bus_rw | output | 1 | 1 = read, 0 = write |
| bus_as_n | output | 1 | Address strobe, active low |
| bus_ds_n | output | 1 | Data strobe, active low |
| bus_cs_n | output | 5 | Chip selects, active low |
| bus_dtack_n | input | 1 | Transfer acknowledge from slave, active low |

## Verification
The bench probes the window edges: the base address, the last address inside a window, and the first address past it. A decoder with an off-by-one comparison would assert a chip select on the miss address or drop the last byte. Overlapping windows, including one that covers the full 64 MB, check the priority order; a reversed priority encoder selects the wrong chip select. Wait counts of 0 and 15 and acknowledges arriving one cycle before and exactly at the timeout limit expose miscounted strobe lengths or a timeout that overrides a valid acknowledge. A full 255-cycle timeout with the reset value confirms the default, and random configurations mixed with random slave delays catch read data latched on the wrong edge.

// File: rtl/csbus_pkg.sv
package csbus_pkg;
    localparam int NUM_PROF = 5;
    localparam int ADDR_W   = 26;
    localparam int DATA_W   = 16;
    localparam int WAIT_W   = 4;
    localparam int TMO_W    = 8;
    localparam int IDX_W    = $clog2(NUM_PROF);
    localparam int SIZE_W   = ADDR_W + 1;

    typedef struct packed {
        logic              en;
        logic              ack;
        logic [WAIT_W-1:0] wait_n;
        logic [ADDR_W-1:0] base;
        logic [SIZE_W-1:0] size;
    } prof_t;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_STROBE  = 2'd1,
        ST_RECOVER = 2'd2
    } cyc_state_t;
endpackage

// File: rtl/csbus_regs.sv
module csbus_regs
    import csbus_pkg::*;
(
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       cfg_we,
    input  logic [IDX_W-1:0]           cfg_idx,
    input  prof_t                      cfg_prof,
    input  logic                       tmo_we,
    input  logic [TMO_W-1:0]           tmo_val,
    output prof_t [NUM_PROF-1:0]       profs,
    output logic [TMO_W-1:0]           tmo_limit
);
    localparam logic [TMO_W-1:0] TMO_RESET = {TMO_W{1'b1}};

    for (genvar p = 0; p < NUM_PROF; p++) begin : g_prof
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                profs[p] <= '0;
            end else if (cfg_we && cfg_idx == IDX_W'(p)) begin
                profs[p] <= cfg_prof;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tmo_limit <= TMO_RESET;
        end else if (tmo_we) begin
            tmo_limit <= tmo_val;
        end
    end
endmodule

// File: rtl/csbus_decode.sv
module csbus_decode
    import csbus_pkg::*;
(
    input  prof_t [NUM_PROF-1:0]  profs,
    input  logic [ADDR_W-1:0]     addr,
    output logic                  hit,
    output logic [IDX_W-1:0]      hit_idx,
    output logic                  sel_ack,
    output logic [WAIT_W-1:0]     sel_wait
);
    logic [NUM_PROF-1:0] match;

    for (genvar p = 0; p < NUM_PROF; p++) begin : g_match
        logic [SIZE_W-1:0] offset;
        assign offset   = {1'b0, addr} - {1'b0, profs[p].base};
        assign match[p] = profs[p].en && (addr >= profs[p].base)
                          && (offset < profs[p].size);
    end

    always_comb begin
        hit     = 1'b0;
        hit_idx = '0;
        for (int i = NUM_PROF - 1; i >= 0; i--) begin
            if (match[i]) begin
                hit     = 1'b1;
                hit_idx = IDX_W'(i);
            end
        end
    end

    assign sel_ack  = profs[hit_idx].ack;
    assign sel_wait = profs[hit_idx].wait_n;
endmodule

// File: rtl/csbus_fsm.sv
module csbus_fsm
    import csbus_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 req_valid,
    input  logic                 req_write,
    input  logic [ADDR_W-1:0]    req_addr,
    input  logic [DATA_W-1:0]    req_wdata,
    input  logic                 hit,
    input  logic [IDX_W-1:0]     hit_idx,
    input  logic                 sel_ack,
    input  logic [WAIT_W-1:0]    sel_wait,
    input  logic [TMO_W-1:0]     tmo_limit,
    input  logic                 bus_dtack_n,
    input  logic [DATA_W-1:0]    bus_din,
    output logic                 req_ready,
    output logic                 resp_done,
    output logic                 resp_err,
    output logic [DATA_W-1:0]    resp_rdata,
    output logic [ADDR_W-1:0]    bus_addr,
    output logic [DATA_W-1:0]    bus_dout,
    output logic                 bus_doe,
    output logic                 bus_rw,
    output logic                 bus_as_n,
    output logic                 bus_ds_n,
    output logic [NUM_PROF-1:0]  bus_cs_n
);
    cyc_state_t state, state_nx;

    logic [IDX_W-1:0]  cur_idx;
    logic              cur_write;
    logic              cur_ack;
    logic [WAIT_W-1:0] cur_wait;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wdata_q;
    logic [TMO_W-1:0]  cnt;
    logic              done_q;
    logic              err_q;
    logic [DATA_W-1:0] rdata_q;

    logic accept;
    logic finish_ok;
    logic finish_tmo;

    assign accept    = (state == ST_IDLE) && req_valid;
    assign finish_ok = cur_ack ? !bus_dtack_n : (cnt == TMO_W'(cur_wait));
    assign finish_tmo = cur_ack && bus_dtack_n
                        && (({1'b0, cnt} + (TMO_W+1)'(1)) >= {1'b0, tmo_limit});

    // next state
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: begin
                if (accept) state_nx = hit ? ST_STROBE : ST_RECOVER;
            end
            ST_STROBE: begin
                if (finish_ok || finish_tmo) state_nx = ST_RECOVER;
            end
            ST_RECOVER: state_nx = ST_IDLE;
            default:    state_nx = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // cycle datapath
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_idx   <= '0;
            cur_write <= 1'b0;
            cur_ack   <= 1'b0;
            cur_wait  <= '0;
            addr_q    <= '0;
            wdata_q   <= '0;
            cnt       <= '0;
            done_q    <= 1'b0;
            err_q     <= 1'b0;
            rdata_q   <= '0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    done_q  <= 1'b0;
                    err_q   <= 1'b0;
                    rdata_q <= '0;
                    if (accept) begin
                        cur_idx   <= hit_idx;
                        cur_write <= req_write;
                        cur_ack   <= sel_ack;
                        cur_wait  <= sel_wait;
                        addr_q    <= req_addr;
                        wdata_q   <= req_wdata;
                        cnt       <= '0;
                        if (!hit) begin
                            done_q <= 1'b1;
                            err_q  <= 1'b1;
                        end
                    end
                end
                ST_STROBE: begin
                    cnt <= cnt + TMO_W'(1);
                    if (finish_ok) begin
                        done_q  <= 1'b1;
                        err_q   <= 1'b0;
                        rdata_q <= cur_write ? '0 : bus_din;
                    end else if (finish_tmo) begin
                        done_q  <= 1'b1;
                        err_q   <= 1'b1;
                        rdata_q <= '0;
                    end
                end
                ST_RECOVER: begin
                    done_q  <= 1'b0;
                    err_q   <= 1'b0;
                    rdata_q <= '0;
                end
                default: begin
                    done_q <= 1'b0;
                    err_q  <= 1'b0;
                end
            endcase
        end
    end

    // outputs
    always_comb begin
        req_ready  = (state == ST_IDLE);
        resp_done  = done_q;
        resp_err   = err_q;
        resp_rdata = rdata_q;
        bus_addr   = addr_q;
        bus_dout   = wdata_q;
        bus_as_n   = 1'b1;
        bus_ds_n   = 1'b1;
        bus_rw     = 1'b1;
        bus_doe    = 1'b0;
        bus_cs_n   = '1;
        unique case (state)
            ST_STROBE: begin
                bus_as_n = 1'b0;
                bus_ds_n = 1'b0;
                bus_rw   = !cur_write;
                bus_doe  = cur_write;
                bus_cs_n = ~(NUM_PROF'(1) << cur_idx);
            end
            ST_IDLE, ST_RECOVER: ;
            default: ;
        endcase
    end
endmodule

// File: rtl/csbus_ctrl.sv
module csbus_ctrl
    import csbus_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cfg_we,
    input  logic [IDX_W-1:0]     cfg_idx,
    input  logic                 cfg_en,
    input  logic                 cfg_ack,
    input  logic [WAIT_W-1:0]    cfg_wait,
    input  logic [ADDR_W-1:0]    cfg_base,
    input  logic [SIZE_W-1:0]    cfg_size,
    input  logic                 tmo_we,
    input  logic [TMO_W-1:0]     tmo_val,
    input  logic                 req_valid,
    input  logic                 req_write,
    input  logic [ADDR_W-1:0]    req_addr,
    input  logic [DATA_W-1:0]    req_wdata,
    output logic                 req_ready,
    output logic                 resp_done,
    output logic                 resp_err,
    output logic [DATA_W-1:0]    resp_rdata,
    output logic [ADDR_W-1:0]    bus_addr,
    output logic [DATA_W-1:0]    bus_dout,
    input  logic [DATA_W-1:0]    bus_din,
    output logic                 bus_doe,
    output logic                 bus_rw,
    output logic                 bus_as_n,
    output logic                 bus_ds_n,
    output logic [NUM_PROF-1:0]  bus_cs_n,
    input  logic                 bus_dtack_n
);
    prof_t [NUM_PROF-1:0] profs;
    prof_t                cfg_prof;
    logic [TMO_W-1:0]     tmo_limit;
    logic                 hit;
    logic [IDX_W-1:0]     hit_idx;
    logic                 sel_ack;
    logic [WAIT_W-1:0]    sel_wait;

    always_comb begin
        cfg_prof.en     = cfg_en;
        cfg_prof.ack    = cfg_ack;
        cfg_prof.wait_n = cfg_wait;
        cfg_prof.base   = cfg_base;
        cfg_prof.size   = cfg_size;
    end

    csbus_regs u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_idx   (cfg_idx),
        .cfg_prof  (cfg_prof),
        .tmo_we    (tmo_we),
        .tmo_val   (tmo_val),
        .profs     (profs),
        .tmo_limit (tmo_limit)
    );

    csbus_decode u_decode (
        .profs    (profs),
        .addr     (req_addr),
        .hit      (hit),
        .hit_idx  (hit_idx),
        .sel_ack  (sel_ack),
        .sel_wait (sel_wait)
    );

    csbus_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_valid   (req_valid),
        .req_write   (req_write),
        .req_addr    (req_addr),
        .req_wdata   (req_wdata),
        .hit         (hit),
        .hit_idx     (hit_idx),
        .sel_ack     (sel_ack),
        .sel_wait    (sel_wait),
        .tmo_limit   (tmo_limit),
        .bus_dtack_n (bus_dtack_n),
        .bus_din     (bus_din),
        .req_ready   (req_ready),
        .resp_done   (resp_done),
        .resp_err    (resp_err),
        .resp_rdata  (resp_rdata),
        .bus_addr    (bus_addr),
        .bus_dout    (bus_dout),
        .bus_doe     (bus_doe),
        .bus_rw      (bus_rw),
        .bus_as_n    (bus_as_n),
        .bus_ds_n    (bus_ds_n),
        .bus_cs_n    (bus_cs_n)
    );
endmodule

// File: rtl/csbus_ctrl_chk.sv
module csbus_ctrl_chk
    import csbus_pkg::*;
(
    input logic                clk,
    input logic                rst_n,
    input logic                req_ready,
    input logic                resp_done,
    input logic                resp_err,
    input logic [ADDR_W-1:0]   bus_addr,
    input logic                bus_doe,
    input logic                bus_rw,
    input logic                bus_as_n,
    input logic                bus_ds_n,
    input logic [NUM_PROF-1:0] bus_cs_n
);
    AST_CS_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~bus_cs_n)); // R3
    AST_CS_NEEDS_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_cs_n != '1) |-> (!bus_as_n && !bus_ds_n)); // R2
    AST_ADDR_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_as_n && $past(!bus_as_n)) |-> $stable(bus_addr)); // R2
    AST_OE_WRITE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        bus_doe |-> (!bus_rw && !bus_as_n)); // R2
    AST_BUSY_NO_READY: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_as_n || resp_done) |-> !req_ready); // R8
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        resp_done |=> !resp_done); // R8
    AST_RECOVER_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        resp_done |-> (bus_as_n && (bus_cs_n == '1))); // R8
    AST_ERR_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        resp_err |-> resp_done); // R4
endmodule

bind csbus_ctrl csbus_ctrl_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_ready (req_ready),
    .resp_done (resp_done),
    .resp_err  (resp_err),
    .bus_addr  (bus_addr),
    .bus_doe   (bus_doe),
    .bus_rw    (bus_rw),
    .bus_as_n  (bus_as_n),
    .bus_ds_n  (bus_ds_n),
    .bus_cs_n  (bus_cs_n)
);

// File: tb/csbus_ctrl_test.sv
module csbus_ctrl_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_idx = '0;
    logic        cfg_en = 1'b0;
    logic        cfg_ack = 1'b0;
    logic [3:0]  cfg_wait = '0;
    logic [25:0] cfg_base = '0;
    logic [26:0] cfg_size = '0;
    logic        tmo_we = 1'b0;
    logic [7:0]  tmo_val = '0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [25:0] req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic        req_ready, resp_done, resp_err;
    logic [15:0] resp_rdata;
    logic [25:0] bus_addr;
    logic [15:0] bus_dout;
    logic [15:0] bus_din = '0;
    logic        bus_doe, bus_rw, bus_as_n, bus_ds_n;
    logic [4:0]  bus_cs_n;
    logic        bus_dtack_n = 1'b1;

    int checks = 0;
    int fails  = 0;

    // model of the programmed profiles
    logic        m_en   [5];
    logic        m_ack  [5];
    int          m_wait [5];
    logic [25:0] m_base [5];
    logic [26:0] m_size [5];
    int          m_tmo = 255;

    always #2.5 clk = ~clk;

    csbus_ctrl uut (.*);

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic int exp_hit(input logic [25:0] a);
        for (int p = 0; p < 5; p++) begin
            if (m_en[p] && (a >= m_base[p]) && ({1'b0, a} - {1'b0, m_base[p]} < m_size[p]))
                return p;
        end
        return -1;
    endfunction

    function automatic logic [15:0] slave_data(input logic [25:0] a);
        return a[15:0] ^ 16'h5A3C ^ {a[25:16], 6'h15};
    endfunction

    task automatic set_prof(input int p, input logic en, input logic ack, input int w,
                            input logic [25:0] base, input logic [26:0] size);
        @(negedge clk);
        cfg_we = 1'b1; cfg_idx = 3'(p); cfg_en = en; cfg_ack = ack;
        cfg_wait = 4'(w); cfg_base = base; cfg_size = size;
        @(negedge clk);
        cfg_we = 1'b0;
        m_en[p] = en; m_ack[p] = ack; m_wait[p] = w; m_base[p] = base; m_size[p] = size;
    endtask

    task automatic set_tmo(input int t);
        @(negedge clk);
        tmo_we = 1'b1; tmo_val = 8'(t);
        @(negedge clk);
        tmo_we = 1'b0;
        m_tmo = t;
    endtask

    // one access; d = acknowledge strobe index (large = never)
    task automatic access(input logic wr, input logic [25:0] a, input logic [15:0] wd,
                          input int d, input string tag);
        int p, strobes, exp_str, teff, guard;
        bit exp_err, bus_bad, cs_bad;
        logic [15:0] rv, exp_rd;
        p = exp_hit(a);
        rv = slave_data(a);
        teff = (m_tmo == 0) ? 1 : m_tmo;
        if (p < 0) begin
            exp_str = 0; exp_err = 1'b1;
        end else if (!m_ack[p]) begin
            exp_str = m_wait[p] + 1; exp_err = 1'b0;
        end else if (d + 1 <= teff) begin
            exp_str = d + 1; exp_err = 1'b0;
        end else begin
            exp_str = teff; exp_err = 1'b1;
        end
        exp_rd = (exp_err || wr) ? 16'h0 : rv;

        @(negedge clk);
        check(req_ready === 1'b1, {tag, " R8 ready before accept"}, req_ready, 1);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = wd;
        bus_din = rv;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        req_addr = ~a;
        strobes = 0; bus_bad = 0; cs_bad = 0; guard = 0;
        while (!resp_done && guard < 400) begin
            if (!bus_as_n) begin
                strobes++;
                if (bus_ds_n !== 1'b0 || bus_addr !== a || bus_rw !== !wr ||
                    bus_doe !== wr || (wr && bus_dout !== wd) || req_ready !== 1'b0)
                    bus_bad = 1;
                if (p < 0 || bus_cs_n !== ~(5'(1) << p)) cs_bad = 1;
                bus_dtack_n = (p >= 0 && m_ack[p] && strobes == d + 1) ? 1'b0 : 1'b1;
            end else begin
                if (bus_cs_n !== 5'h1F) cs_bad = 1;
            end
            guard++;
            @(negedge clk);
        end
        bus_dtack_n = 1'b1;
        check(resp_done === 1'b1, {tag, " R8 done seen"}, resp_done, 1);
        check(strobes == exp_str, {tag, " R5/R6/R7 strobe length"}, strobes, exp_str);
        check(!bus_bad, {tag, " R2 bus signals during strobe"}, bus_bad, 0);
        check(!cs_bad, {tag, " R3 chip select"}, cs_bad, 0);
        check(resp_err === exp_err, {tag, " R4/R7 error flag"}, resp_err, exp_err);
        check(resp_rdata === exp_rd, {tag, " R9 read data"}, resp_rdata, exp_rd);
        check(bus_as_n === 1'b1 && bus_cs_n === 5'h1F && req_ready === 1'b0,
              {tag, " R8 recovery cycle"}, {bus_as_n, bus_cs_n, req_ready}, 7'b1111110);
        @(negedge clk);
        check(resp_done === 1'b0 && req_ready === 1'b1, {tag, " R8 single done pulse"},
              {resp_done, req_ready}, 2'b01);
    endtask

    initial begin
        repeat (180000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        for (int p = 0; p < 5; p++) begin
            m_en[p] = 0; m_ack[p] = 0; m_wait[p] = 0; m_base[p] = '0; m_size[p] = '0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(req_ready === 1'b1 && bus_as_n === 1'b1 && bus_ds_n === 1'b1,
              "R1 ready and strobes idle", {req_ready, bus_as_n, bus_ds_n}, 3'b111);
        check(bus_cs_n === 5'h1F && resp_done === 1'b0, "R1 selects and done idle",
              {bus_cs_n, resp_done}, 6'b111110);
        // R1: profiles disabled -> miss (R4)
        access(1'b0, 26'h0000010, 16'h0, 0, "R1 disabled profiles");

        set_prof(0, 1, 0, 0,  26'h0000000, 27'h1000);
        set_prof(1, 1, 0, 15, 26'h0001000, 27'h1000);
        set_prof(2, 1, 1, 0,  26'h0010000, 27'h100);
        set_prof(4, 1, 1, 0,  26'h0020000, 27'h10);
        access(1'b0, 26'h0000000, 16'h0,    0, "R3 base of p0 wait0");
        access(1'b1, 26'h0000FFF, 16'hBEEF, 0, "R3 last of p0 write");
        access(1'b0, 26'h0001000, 16'h0,    0, "R5 p1 wait15");
        access(1'b0, 26'h0001FFF, 16'h0,    0, "R3 last of p1");
        access(1'b0, 26'h0002000, 16'h0,    0, "R4 past p1 miss");
        access(1'b0, 26'h0010020, 16'h0,    0, "R6 ack immediate");
        access(1'b1, 26'h00100FF, 16'h1234, 7, "R6 ack delay7 write");
        access(1'b0, 26'h0020005, 16'h0,    30, "R6 ack delay30 p4");
        // R7 default 255 timeout
        access(1'b0, 26'h0010001, 16'h0, 1000, "R7 default timeout");
        set_tmo(10);
        access(1'b0, 26'h0010002, 16'h0, 9,  "R7 ack at last cycle");
        access(1'b0, 26'h0010003, 16'h0, 10, "R7 ack too late");
        set_tmo(0);
        access(1'b0, 26'h0010004, 16'h0, 1000, "R7 zero timeout");
        // R3 overlap priority and full 64MB window
        set_prof(3, 1, 0, 2, 26'h0000000, 27'h4000000);
        access(1'b0, 26'h0000800,  16'h0, 0, "R3 overlap p0 wins");
        access(1'b0, 26'h3FFFFFF,  16'h0, 0, "R3 full window top");
        access(1'b1, 26'h0002000,  16'hA5A5, 0, "R3 full window fill");

        // constrained random rounds
        for (int r = 0; r < 8; r++) begin
            for (int p = 0; p < 5; p++)
                set_prof(p, ($urandom % 5) != 0, $urandom % 2, $urandom % 16,
                         26'($urandom), 27'($urandom_range(1, 4096)));
            set_tmo($urandom_range(1, 40));
            for (int k = 0; k < 20; k++) begin
                int p;
                logic [25:0] a;
                p = $urandom % 5;
                if ($urandom % 4 == 0) a = 26'($urandom);
                else a = 26'(m_base[p] + 26'($urandom % (32'(m_size[p]) + 1)));
                access($urandom % 2, a, 16'($urandom), $urandom_range(0, 45), "R3 random");
            end
        end

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule